// File: doc/BRIEF.md
# Edge-Kicked Watchdog Timer

This block watches one activity line driven by a processor. Every change of level on that line, rising or falling, counts as a kick and restarts a cycle counter. When the line keeps one level for a full timeout, the active-low alarm output falls. It stays low until the next kick arrives. The timeout is a parameter counted in clock cycles. A nominal 1.6 s window, allowed to lie between 1.0 s and 2.25 s, becomes the product of that time and the clock frequency. The clock must also run fast enough to sample a 50 ns pulse on the activity line.

A supply-fault flag pulls the alarm low combinationally, whatever the activity line is doing. An enable input turns the timeout off, and with it low the output tracks only the supply flag. To turn a timeout into a system reset, route the alarm to the manual-reset input of a separate reset generator.

Top module: `edge_wdog`

## Requirements
- R1: After reset with the supply flag clear, `wdog_n` is 1.
- R2: A low-to-high change on `kick_in` restarts the timeout count from zero.
- R3: A high-to-low change on `kick_in` restarts the timeout count from zero.
- R4: With `enable`=1 and `supply_low`=0, if `kick_in` keeps its level, `wdog_n` falls at the (TIMEOUT_CYCLES+3)th rising clock edge after the change. Edge 1 is the first edge that samples the new level. Two of those edges are the synchronizer and one is the edge detector. The output is still 1 after edge TIMEOUT_CYCLES+2.
- R5: Once timed out, `wdog_n` returns to 1 at the 3rd rising edge after the next change on `kick_in`.
- R6: While `supply_low`=1, `wdog_n` is 0 in the same cycle, whatever `kick_in` and `enable` do.
- R7: When `supply_low` clears, `wdog_n` is 1 at once and a full timeout restarts from zero. With no kick, the output falls at the TIMEOUT_CYCLES-th rising edge after the clear.
- R8: While `enable`=0 and `supply_low`=0, `wdog_n` stays 1 however long `kick_in` is idle.
- R9: When `enable` rises, the count restarts from zero. With no kick, the output falls at the TIMEOUT_CYCLES-th rising edge after the rise.
- R10: A `kick_in` pulse that lasts a single clock period counts as a kick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| kick_in | input | 1 | Asynchronous activity line from the processor |
| enable | input | 1 | 1 runs the timeout, 0 disables it |
| supply_low | input | 1 | Supply-fault flag, 1 means the supply is below its valid level |
| wdog_n | output | 1 | Alarm output, 0 on timeout or supply fault |

## Verification
A counter that restarts late or early moves the falling edge of `wdog_n` by whole cycles. The bench therefore pins that edge to one exact clock for both edge polarities, after a supply clear and after an enable rise. An expiry flag that is never cleared, or is cleared late, shows as a missed or delayed recovery within three cycles of a kick. A supply-flag path with a register in it shows up in the very cycle the flag rises.

// File: rtl/edge_wdog_pkg.sv
package edge_wdog_pkg;
   // Edge events seen on the synchronized activity line
   typedef struct packed {
      logic rise;
      logic fall;
   } edge_evt_t;

   localparam int unsigned MIN_SYNC_STAGES = 2;
   localparam int unsigned MIN_TIMEOUT     = 4;
endpackage

// File: rtl/edge_wdog_sync.sv
module edge_wdog_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < edge_wdog_pkg::MIN_SYNC_STAGES) begin : g_bad_stages
      $error("edge_wdog_sync: STAGES below minimum");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/edge_wdog_edge.sv
module edge_wdog_edge
   import edge_wdog_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      lvl,
   output edge_evt_t evt
);
   logic lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl;
   end

   always_comb begin
      evt.rise = lvl & ~lvl_q;
      evt.fall = ~lvl & lvl_q;
   end
endmodule

// File: rtl/edge_wdog_timer.sv
module edge_wdog_timer #(
   parameter int unsigned TIMEOUT_CYCLES = 1600,
   parameter int unsigned CNT_W          = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             kick,
   output logic [CNT_W-1:0] cnt,
   output logic             expired
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);

   if (TIMEOUT_CYCLES < edge_wdog_pkg::MIN_TIMEOUT) begin : g_bad_timeout
      $error("edge_wdog_timer: TIMEOUT_CYCLES below minimum");
   end
   if ((1 << CNT_W) < TIMEOUT_CYCLES) begin : g_bad_width
      $error("edge_wdog_timer: CNT_W too narrow");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         expired <= 1'b0;
      end else if (!run || kick) begin
         cnt     <= '0;
         expired <= 1'b0;
      end else if (cnt == LAST) begin
         expired <= 1'b1;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/edge_wdog.sv
module edge_wdog
   import edge_wdog_pkg::*;
#(
   parameter int unsigned TIMEOUT_CYCLES = 1600,
   parameter int unsigned SYNC_STAGES    = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kick_in,
   input  logic enable,
   input  logic supply_low,
   output logic wdog_n
);
   localparam int unsigned CNT_W = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;

   logic             kick_sync;
   edge_evt_t        evt;
   logic             kick;
   logic             run;
   logic [CNT_W-1:0] cnt;
   logic             expired;

   edge_wdog_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (kick_in),
      .q     (kick_sync)
   );

   edge_wdog_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (kick_sync),
      .evt   (evt)
   );

   assign kick = evt.rise | evt.fall;
   assign run  = enable & ~supply_low;

   edge_wdog_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES), .CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .kick    (kick),
      .cnt     (cnt),
      .expired (expired)
   );

   // supply fault overrides without any register in the path
   assign wdog_n = ~(supply_low | (enable & expired));
endmodule

// File: rtl/edge_wdog_chk.sv
module edge_wdog_chk #(
   parameter int unsigned TIMEOUT_CYCLES = 1600,
   parameter int unsigned CNT_W          = 11
) (
   input logic             clk,
   input logic             rst_n,
   input logic             enable,
   input logic             supply_low,
   input logic             wdog_n,
   input logic             kick,
   input logic [CNT_W-1:0] cnt,
   input logic             expired
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);

   a_r6_supply_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
      supply_low |-> !wdog_n);

   a_r8_disabled_high: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !supply_low) |-> wdog_n);

   a_r2_kick_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      (kick && enable && !supply_low) |=> (cnt == '0 && !expired));

   a_r4_expiry_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(expired) |-> ($past(cnt) == LAST));

   a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);

   a_r5_recover: assert property (@(posedge clk) disable iff (!rst_n)
      (expired && kick && enable && !supply_low) |=> (wdog_n || supply_low));

   a_r7_supply_restart: assert property (@(posedge clk) disable iff (!rst_n)
      $past(supply_low) |-> (cnt == '0 && !expired));

   a_r9_enable_restart: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!enable) |-> (cnt == '0 && !expired));
endmodule

bind edge_wdog edge_wdog_chk #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES), .CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .enable     (enable),
   .supply_low (supply_low),
   .wdog_n     (wdog_n),
   .kick       (kick),
   .cnt        (cnt),
   .expired    (expired)
);

// File: tb/edge_wdog_bench.sv
module edge_wdog_bench;
   localparam int unsigned T = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic kick_in = 1'b0;
   logic enable = 1'b1;
   logic supply_low = 1'b0;
   logic wdog_n;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   edge_wdog #(.TIMEOUT_CYCLES(T), .SYNC_STAGES(2)) u_edge_wdog (
      .clk        (clk),
      .rst_n      (rst_n),
      .kick_in    (kick_in),
      .enable     (enable),
      .supply_low (supply_low),
      .wdog_n     (wdog_n)
   );

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: wdog_n=%b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic toggle();
      @(negedge clk);
      kick_in = ~kick_in;
   endtask

   task automatic test_reset();
      check("R1 reset state", wdog_n, 1'b1);
      edges(3);
      check("R1 after release", wdog_n, 1'b1);
   endtask

   // R4: held level times out at exact edge; kick direction selects R2 or R3
   task automatic test_hold(input string req);
      toggle();
      edges(T + 2);
      check(req, wdog_n, 1'b1);
      edges(1);
      check(req, wdog_n, 1'b0);
   endtask

   task automatic test_recover();
      toggle();
      edges(2);
      check("R5 still low", wdog_n, 1'b0);
      edges(1);
      check("R5 recovered", wdog_n, 1'b1);
   endtask

   task automatic test_periodic();
      for (int i = 0; i < 5; i++) begin
         toggle();
         edges(T / 2);
         check("R2 R3 kicked stays high", wdog_n, 1'b1);
      end
   endtask

   task automatic test_supply();
      toggle();
      edges(4);
      @(negedge clk);
      supply_low = 1'b1;
      #1;
      check("R6 immediate low", wdog_n, 1'b0);
      for (int i = 0; i < 4; i++) begin
         toggle();
         #1;
         check("R6 low while kicking", wdog_n, 1'b0);
      end
      enable = 1'b0;
      #1;
      check("R6 low while disabled", wdog_n, 1'b0);
      enable = 1'b1;
      edges(6);
      @(negedge clk);
      supply_low = 1'b0;
      #1;
      check("R7 high on clear", wdog_n, 1'b1);
      edges(T - 1);
      check("R7 full window", wdog_n, 1'b1);
      edges(1);
      check("R7 timeout from clear", wdog_n, 1'b0);
   endtask

   task automatic test_disable();
      @(negedge clk);
      enable = 1'b0;
      #1;
      check("R8 high when disabled", wdog_n, 1'b1);
      edges(3 * T);
      check("R8 idle disabled", wdog_n, 1'b1);
      @(negedge clk);
      enable = 1'b1;
      #1;
      check("R9 high on enable", wdog_n, 1'b1);
      edges(T - 1);
      check("R9 full window", wdog_n, 1'b1);
      edges(1);
      check("R9 timeout from enable", wdog_n, 1'b0);
   endtask

   task automatic test_short_pulse();
      toggle();
      edges(T + 4);
      check("R10 expired before pulse", wdog_n, 1'b0);
      toggle();
      toggle();
      edges(2);
      check("R10 pulse kicked", wdog_n, 1'b1);
      edges(T);
      check("R10 timer restarted", wdog_n, 1'b1);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1 during reset", wdog_n, 1'b1);
      @(negedge clk);
      rst_n = 1'b1;
      test_reset();
      test_periodic();
      test_hold("R2 R4 rise then hold");
      test_recover();
      test_hold("R3 R4 fall then hold");
      test_recover();
      test_supply();
      test_recover();
      test_disable();
      test_recover();
      test_short_pulse();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule